// File: doc/BRIEF.md
# Instruction Address Trap Unit

This block watches the internal 24-bit address bus of a processor. It raises an interrupt request when an instruction fetch reaches one of three programmable trap addresses. Each channel stores a trap address in three byte-wide registers. Address bit 0 is not stored, so every trap address is even and the comparison works at halfword granularity. A match counts only in the cycle where the bus marks the fetch of an instruction's first byte. The channel's enable bit must also be set.

A matching fetch sets a sticky pending flag in that channel. Software clears the flag by writing 1 to it. The interrupt output is the OR, over all channels, of each pending flag gated by that channel's enable. Software reaches the registers through a small byte-wide register port with a 5-bit address. Writes take effect at the next clock edge. Reads are combinational.

Register layout: channel c uses byte addresses 4c to 4c+3. Offset 0 holds trap address bits 23:16. Offset 1 holds bits 15:8. Offset 2 holds bits 7:1 in its bits 7:1, and its bit 0 is always 0. Offset 3 is the control byte: bit 0 is enable (read/write), bit 1 is pending (read, write 1 to clear), and bits 7:2 read 0. Addresses 12 to 31 are unmapped.

Top module: `fetch_trap_unit`

## Requirements
- R1: After reset every mapped register reads 0x00 and trapIrq is 0.
- R2: Offsets 0 and 1 of each channel read back the last byte written to them. A write to one channel leaves the other channels unchanged.
- R3: Offset 2 stores written bits 7:1. Its bit 0 ignores writes and always reads 0.
- R4: A channel matches when fetchFirst is 1, its enable bit is 1, and fetchAddr[23:1] equals its stored address; fetchAddr[0] plays no part. The pending bit (control bit 1) is set at that clock edge, and trapIrq is 1 from that edge on.
- R5: With fetchFirst at 0, no fetch address sets a pending bit.
- R6: A channel whose enable bit is 0 never sets its pending bit.
- R7: A fetch whose bits 23:1 differ from the stored address in any bit leaves the pending bit clear.
- R8: A pending bit stays set until a control-byte write with bit 1 = 1. A write with bit 1 = 0 leaves the pending bit as it was.
- R9: When a match and a clearing write hit the same channel in the same cycle, the pending bit ends up set.
- R10: trapIrq is 1 exactly when some channel has both enable and pending at 1. Clearing enable drops trapIrq and keeps the pending bit readable as 1.
- R11: A fetch in the same cycle as a register write to that channel compares against the register values from before the write.
- R12: Unmapped addresses (12 to 31) read 0x00, and writes to them change no register.
- R13: regRdData is 0x00 whenever regRdEn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| regAddr | input | 5 | Register byte address |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data |
| fetchAddr | input | 24 | Internal address bus |
| fetchFirst | input | 1 | Marks the fetch of an instruction's first byte |
| trapIrq | output | 1 | Combined interrupt request |

## Verification
Read data depends on no clock edge. The bench samples it 1 ns after setting the address and read strobe, within the same low clock phase. Writes and pending bits change at the rising edge that captures the strobe. The bench applies each write or fetch in one low phase, and at the next falling edge it compares trapIrq against its model, which has advanced by exactly one edge. Same-cycle write/fetch cases evaluate the model's match with the pre-write values before applying the write.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int ADDR_W    = 24;
  localparam int TRAP_W    = ADDR_W - 1;
  localparam int REG_AW    = 5;
  localparam int CH_SEL_W  = 3;

  typedef enum logic [1:0] {
    FLD_HIGH = 2'd0,
    FLD_MID  = 2'd1,
    FLD_LOW  = 2'd2,
    FLD_CTL  = 2'd3
  } regField_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_PEND_BIT = 1;

  typedef struct packed {
    logic                wr;
    logic                rd;
    logic [CH_SEL_W-1:0] ch;
    regField_e           fld;
    logic [7:0]          data;
  } regStrobe_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regWrData,
  output regStrobe_t        stb
);
  logic [CH_SEL_W-1:0] chIdx;
  logic                inRange;

  assign chIdx   = regAddr[REG_AW-1:2];
  assign inRange = (chIdx < CH_SEL_W'(NUM_CH));

  always_comb begin
    stb.wr   = regWrEn && inRange;
    stb.rd   = regRdEn && inRange;
    stb.ch   = chIdx;
    stb.fld  = regField_e'(regAddr[1:0]);
    stb.data = regWrData;
  end
endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  regStrobe_t               stb,
  input  logic [ADDR_W-1:0]        fetchAddr,
  input  logic                     fetchFirst,
  output logic [7:0]               rdData,
  output logic [NUM_CH-1:0]        chEn,
  output logic [NUM_CH-1:0]        chPend,
  output logic [NUM_CH*TRAP_W-1:0] chAddr
);
  logic [7:0] rdByte [NUM_CH][4];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [7:0] hiQ, midQ;
    logic [6:0] loQ;
    logic       enQ, pendQ;
    logic       selCh, hit, clrReq;

    assign selCh  = stb.wr && (stb.ch == CH_SEL_W'(c));
    assign hit    = fetchFirst && enQ &&
                    (fetchAddr[ADDR_W-1:1] == {hiQ, midQ, loQ});
    assign clrReq = selCh && (stb.fld == FLD_CTL) && stb.data[CTL_PEND_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hiQ   <= '0;
        midQ  <= '0;
        loQ   <= '0;
        enQ   <= 1'b0;
        pendQ <= 1'b0;
      end else begin
        if (selCh) begin
          unique case (stb.fld)
            FLD_HIGH: hiQ  <= stb.data;
            FLD_MID:  midQ <= stb.data;
            FLD_LOW:  loQ  <= stb.data[7:1];
            FLD_CTL:  enQ  <= stb.data[CTL_EN_BIT];
          endcase
        end
        if (hit)         pendQ <= 1'b1;
        else if (clrReq) pendQ <= 1'b0;
      end
    end

    assign rdByte[c][0] = hiQ;
    assign rdByte[c][1] = midQ;
    assign rdByte[c][2] = {loQ, 1'b0};
    assign rdByte[c][3] = {6'b0, pendQ, enQ};

    assign chEn[c]                     = enQ;
    assign chPend[c]                   = pendQ;
    assign chAddr[c*TRAP_W +: TRAP_W]  = {hiQ, midQ, loQ};
  end

  always_comb begin
    rdData = '0;
    if (stb.rd) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (stb.ch == CH_SEL_W'(c)) rdData = rdByte[c][stb.fld];
      end
    end
  end
endmodule

// File: rtl/fetch_trap_unit.sv
module fetch_trap_unit
  import trap_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchFirst,
  output logic              trapIrq
);
  regStrobe_t               stb;
  logic [NUM_CH-1:0]        chEn;
  logic [NUM_CH-1:0]        chPend;
  logic [NUM_CH*TRAP_W-1:0] chAddr;

  trap_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regWrData(regWrData),
    .stb      (stb)
  );

  trap_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .fetchAddr (fetchAddr),
    .fetchFirst(fetchFirst),
    .rdData    (regRdData),
    .chEn      (chEn),
    .chPend    (chPend),
    .chAddr    (chAddr)
  );

  assign trapIrq = |(chEn & chPend);
endmodule

// File: rtl/trap_checker.sv
module trap_checker
  import trap_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [REG_AW-1:0]        regAddr,
  input logic                     regWrEn,
  input logic                     regRdEn,
  input logic [7:0]               regWrData,
  input logic [7:0]               regRdData,
  input logic [ADDR_W-1:0]        fetchAddr,
  input logic                     fetchFirst,
  input logic                     trapIrq,
  input logic [NUM_CH-1:0]        chEn,
  input logic [NUM_CH-1:0]        chPend,
  input logic [NUM_CH*TRAP_W-1:0] chAddr
);
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!trapIrq && chPend == '0 && chEn == '0); // R1
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !regRdEn |-> regRdData == 8'h00); // R13

  AST_LOW_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && regAddr[1:0] == 2'd2) |-> !regRdData[0]); // R3

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_HIT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (fetchFirst && chEn[c] && fetchAddr[ADDR_W-1:1] == chAddr[c*TRAP_W +: TRAP_W])
      |=> chPend[c]); // R4
    AST_NO_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetchFirst && !chPend[c]) |=> !chPend[c]); // R5
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!chEn[c] && !chPend[c]) |=> !chPend[c]); // R6
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (chPend[c] && !(regWrEn && regAddr == REG_AW'(c*4+3) && regWrData[1]))
      |=> chPend[c]); // R8
  end
endmodule

bind fetch_trap_unit trap_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .fetchAddr (fetchAddr),
  .fetchFirst(fetchFirst),
  .trapIrq   (trapIrq),
  .chEn      (chEn),
  .chPend    (chPend),
  .chAddr    (chAddr)
);

// File: tb/tb_fetch_trap_unit.sv
`timescale 1ns/1ps
module tb_fetch_trap_unit;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [23:0] fetchAddr = '0;
  logic        fetchFirst = 1'b0;
  logic        trapIrq;

  int nChk = 0;
  int nErr = 0;

  logic [7:0] mHi [NCH];
  logic [7:0] mMid[NCH];
  logic [6:0] mLo [NCH];
  logic       mEn [NCH];
  logic       mPend[NCH];

  always #5 clk = ~clk;

  fetch_trap_unit dut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .fetchAddr(fetchAddr), .fetchFirst(fetchFirst), .trapIrq(trapIrq)
  );

  function automatic logic [7:0] expRead(input logic [4:0] a);
    int c;
    c = int'(a[4:2]);
    if (c >= NCH) return 8'h00;
    case (a[1:0])
      2'd0: return mHi[c];
      2'd1: return mMid[c];
      2'd2: return {mLo[c], 1'b0};
      default: return {6'b0, mPend[c], mEn[c]};
    endcase
  endfunction

  function automatic logic expIrq();
    logic r;
    r = 1'b0;
    for (int c = 0; c < NCH; c++) r |= mEn[c] & mPend[c];
    return r;
  endfunction

  function automatic logic [22:0] trapOf(input int c);
    return {mHi[c], mMid[c], mLo[c]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic readChk(input logic [4:0] a, input string req);
    regAddr = a;
    regRdEn = 1'b1;
    #1;
    check(req, regRdData, expRead(a));
    regRdEn = 1'b0;
    #1;
    check("R13", regRdData, 8'h00);
  endtask

  // One clock cycle with optional write and fetch; model updated with pre-write values (R11)
  task automatic step(input logic wr, input logic [4:0] wa, input logic [7:0] wd,
                      input logic ff, input logic [23:0] fa, input string req);
    logic hitV[NCH];
    logic clrV[NCH];
    int   c;
    @(negedge clk);
    regWrEn = wr; regAddr = wa; regWrData = wd;
    fetchFirst = ff; fetchAddr = fa;
    for (int k = 0; k < NCH; k++) begin
      hitV[k] = ff && mEn[k] && (fa[23:1] == trapOf(k));
      clrV[k] = 1'b0;
    end
    c = int'(wa[4:2]);
    if (wr && c < NCH) begin
      case (wa[1:0])
        2'd0: mHi[c]  = wd;
        2'd1: mMid[c] = wd;
        2'd2: mLo[c]  = wd[7:1];
        default: begin mEn[c] = wd[0]; clrV[c] = wd[1]; end
      endcase
    end
    for (int k = 0; k < NCH; k++) mPend[k] = hitV[k] | (mPend[k] & ~clrV[k]);
    @(negedge clk);
    regWrEn = 1'b0; fetchFirst = 1'b0;
    check(req, {7'b0, trapIrq}, {7'b0, expIrq()});
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input string req);
    step(1'b1, a, d, 1'b0, 24'h0, req);
  endtask

  task automatic fetch(input logic [23:0] fa, input logic ff, input string req);
    step(1'b0, 5'd0, 8'h00, ff, fa, req);
  endtask

  initial begin
    #(200000 * 10);
    nErr++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) begin
      mHi[c] = 0; mMid[c] = 0; mLo[c] = 0; mEn[c] = 0; mPend[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", {7'b0, trapIrq}, 8'h00);
    for (int a = 0; a < 16; a++) readChk(5'(a), "R1");

    // R2 byte read-back, other channels untouched
    wr(5'd4, 8'hA5, "R2"); wr(5'd5, 8'h3C, "R2");
    readChk(5'd4, "R2"); readChk(5'd5, "R2"); readChk(5'd0, "R2"); readChk(5'd8, "R2");
    // R3 low bit fixed
    wr(5'd2, 8'hFF, "R3"); readChk(5'd2, "R3");
    // R4 match at 0x123456 via odd address 0x123457 on channel 2
    wr(5'd8, 8'h12, "R4"); wr(5'd9, 8'h34, "R4"); wr(5'd10, 8'h56, "R4");
    wr(5'd11, 8'h01, "R4");
    fetch(24'h123457, 1'b1, "R4"); readChk(5'd11, "R4");
    // R8 write 0 to pending keeps it; write 1 clears
    wr(5'd11, 8'h01, "R8"); readChk(5'd11, "R8");
    wr(5'd11, 8'h03, "R8"); readChk(5'd11, "R8");
    // R5 qualifier low
    fetch(24'h123456, 1'b0, "R5"); readChk(5'd11, "R5");
    // R7 single-bit differences
    fetch(24'h923456, 1'b1, "R7"); fetch(24'h123454, 1'b1, "R7"); readChk(5'd11, "R7");
    // R6 disabled channel
    wr(5'd11, 8'h00, "R6"); fetch(24'h123456, 1'b1, "R6"); readChk(5'd11, "R6");
    // R9 set beats clear
    wr(5'd11, 8'h01, "R9");
    step(1'b1, 5'd11, 8'h03, 1'b1, 24'h123456, "R9"); readChk(5'd11, "R9");
    // R10 dropping enable masks the request, pending stays
    wr(5'd11, 8'h00, "R10"); readChk(5'd11, "R10");
    wr(5'd11, 8'h03, "R10");
    // R11 same-cycle write uses old value
    wr(5'd11, 8'h01, "R11");
    step(1'b1, 5'd10, 8'h78, 1'b1, 24'h123456, "R11"); readChk(5'd11, "R11");
    wr(5'd11, 8'h03, "R11");
    step(1'b1, 5'd10, 8'h9A, 1'b1, 24'h12349A, "R11"); readChk(5'd11, "R11");
    // R12 unmapped writes ignored
    wr(5'd13, 8'hFF, "R12"); wr(5'd31, 8'hFF, "R12");
    for (int a = 0; a < 32; a++) readChk(5'(a), "R12");

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int op, c;
      logic [23:0] fa;
      op = int'($urandom % 4);
      c  = int'($urandom % NCH);
      fa = {trapOf(c), 1'($urandom)};
      case (op)
        0: wr(5'($urandom % 16), 8'($urandom), "R2");
        1: fetch(fa, ($urandom % 4) != 0, "R4");
        2: fetch(24'($urandom), 1'b1, "R7");
        default: step(1'b1, 5'(c*4 + int'($urandom % 4)), 8'($urandom),
                      1'b1, fa, "R11");
      endcase
      readChk(5'($urandom % 32), "R10");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule